// File: doc/BRIEF.md
# Histogram Ring-Center Finder

This block looks for circular hit patterns in one event of detector hits. Hits arrive one (x, y) pair per beat on a valid/ready input, and a beat flagged as end-of-event closes the event. A square array of candidate center points sits over the XY plane. The origin and pitch of the array are set on configuration inputs. Each candidate center keeps a histogram of quantised center-to-hit distances. Every hit adds one count to one bin of every center's histogram.

After the closing beat the block visits the centers one at a time. A center whose fullest bin reaches a programmable threshold is reported as a ring candidate, and its fullest bin gives the radius. For each candidate the block replays the stored hits of the event and counts those whose distance bin lies next to the radius or on it. That count is the number of hits a later circle fit would use. Results leave on a valid/ready output, one record per candidate. A single "no candidate" record is sent when no center qualifies. The histograms are then wiped and the input reopens for the next event.

Top module: `ringcand_finder`

## Requirements
- R1: The center at column i and row j (0..3) lies at (cfg_org_x + i*cfg_step, cfg_org_y + j*cfg_step), with no truncation.
- R2: The bin of a hit for a center is min(15, (max(|dx|,|dy|) + floor(min(|dx|,|dy|)/2)) >> 3).
- R3: Each hit beat (in_valid, in_ready, in_eoe=0) adds 1 to exactly one bin of every center. Bin counts are 8 bits wide and hold at 255 instead of wrapping.
- R4: A center is a candidate when its largest bin count is >= cfg_thresh. The record gives that count as out_peak and the lowest bin index holding it as out_radius.
- R5: Candidate records come out in row-major order, column index fastest. While out_valid is high and out_ready is low, every output field stays unchanged.
- R6: out_annulus equals the number of stored hits of the event whose bin for that center differs from out_radius by at most 1.
- R7: Only the first 64 hits of an event are stored for the annulus count. Later hits still count in the histograms. The hit that finds storage full sets `overflow`, which stays at 1 until reset.
- R8: When no center is a candidate, exactly one record is sent with out_none=1 and all other fields 0. Candidate records carry out_none=0.
- R9: in_ready is 0 from the cycle after the end-of-event beat until the histograms have been cleared after the last record. Each event's results depend only on that event's hits.
- R10: During and right after reset, out_valid and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_org_x | input | 8 | X of the center at column 0 |
| cfg_org_y | input | 8 | Y of the center at row 0 |
| cfg_step | input | 8 | Pitch between neighbouring centers |
| cfg_thresh | input | 8 | Minimum peak count for a candidate |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_eoe | input | 1 | Beat is the end-of-event marker (coordinates ignored) |
| in_x | input | 8 | Hit x coordinate |
| in_y | input | 8 | Hit y coordinate |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_gx | output | 2 | Center column index |
| out_gy | output | 2 | Center row index |
| out_radius | output | 4 | Radius bin |
| out_peak | output | 8 | Count in the radius bin |
| out_annulus | output | 7 | Stored hits within one bin of the radius |
| out_none | output | 1 | Event had no candidate |
| overflow | output | 1 | Sticky: an event held more hits than the store |

## Verification
The records are the only visible product of the hidden histograms, so a wrong count, a missed clear or a mis-scanned center shows up in the very next record of the event. It appears as a wrong peak, a wrong radius, a changed candidate set or wrong ordering, and the reference model sees it at the handshake. A storage or replay fault shows up only in out_annulus. A failure to clear shows up in the following event, which is why events with very different hit sets are run back to back. A saturation fault needs more than 255 hits on one bin before it becomes visible.

// File: rtl/ringcand_pkg.sv
package ringcand_pkg;
  typedef enum logic [2:0] {
    ST_CLR  = 3'd0,
    ST_ACC  = 3'd1,
    ST_SCAN = 3'd2,
    ST_ANN  = 3'd3,
    ST_OUT  = 3'd4
  } rc_state_t;
endpackage

// File: rtl/ringcand_dist.sv
module ringcand_dist #(
  parameter int HW     = 8,
  parameter int CW     = 11,
  parameter int NBINS  = 16,
  parameter int SHIFT  = 3,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic [HW-1:0]    hx,
  input  logic [HW-1:0]    hy,
  input  logic [CW-1:0]    cx,
  input  logic [CW-1:0]    cy,
  output logic [BIN_W-1:0] bin
);
  logic [CW-1:0] hxw, hyw, adx, ady, mx, mn;
  logic [CW:0]   dsum, dsh;

  always_comb begin
    hxw  = CW'(hx);
    hyw  = CW'(hy);
    adx  = (hxw > cx) ? hxw - cx : cx - hxw;
    ady  = (hyw > cy) ? hyw - cy : cy - hyw;
    mx   = (adx > ady) ? adx : ady;
    mn   = (adx > ady) ? ady : adx;
    dsum = {1'b0, mx} + {2'b0, mn[CW-1:1]};
    dsh  = dsum >> SHIFT;
    bin  = (dsh > (CW+1)'(NBINS - 1)) ? BIN_W'(NBINS - 1) : dsh[BIN_W-1:0];
  end
endmodule

// File: rtl/ringcand_hist.sv
module ringcand_hist #(
  parameter int NBINS  = 16,
  parameter int CNT_W  = 8,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [BIN_W-1:0] bin,
  output logic [CNT_W-1:0] peak,
  output logic [BIN_W-1:0] peak_bin
);
  logic [CNT_W-1:0] cnt [NBINS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int b = 0; b < NBINS; b++) cnt[b] <= '0;
    end else if (inc && (cnt[bin] != {CNT_W{1'b1}})) begin
      cnt[bin] <= cnt[bin] + 1'b1;
    end
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    peak     = cnt[0];
    peak_bin = '0;
    for (int b = 1; b < NBINS; b++) begin
      if (cnt[b] > peak) begin
        peak     = cnt[b];
        peak_bin = BIN_W'(b);
      end
    end
  end

  assert_peak_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> peak >= $past(peak));
  assert_peak_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(peak));
endmodule

// File: rtl/ringcand_hitbuf.sv
module ringcand_hitbuf #(
  parameter int W      = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ringcand_finder.sv
module ringcand_finder #(
  parameter int COORD_W   = 8,
  parameter int GRID_N    = 4,
  parameter int NBINS     = 16,
  parameter int CNT_W     = 8,
  parameter int BIN_SHIFT = 3,
  parameter int HIT_DEPTH = 64,
  localparam int GX_W  = $clog2(GRID_N),
  localparam int BIN_W = $clog2(NBINS),
  localparam int NH_W  = $clog2(HIT_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] cfg_org_x,
  input  logic [COORD_W-1:0] cfg_org_y,
  input  logic [COORD_W-1:0] cfg_step,
  input  logic [CNT_W-1:0]   cfg_thresh,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_eoe,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [GX_W-1:0]    out_gx,
  output logic [GX_W-1:0]    out_gy,
  output logic [BIN_W-1:0]   out_radius,
  output logic [CNT_W-1:0]   out_peak,
  output logic [NH_W-1:0]    out_annulus,
  output logic               out_none,
  output logic               overflow
);
  import ringcand_pkg::*;

  localparam int NPTS = GRID_N * GRID_N;
  localparam int GP_W = 2 * GX_W;
  localparam int CW   = COORD_W + GX_W + 1;
  localparam int AW   = $clog2(HIT_DEPTH);

  rc_state_t        state;
  logic [GP_W-1:0]  gp;
  logic             any_cand;
  logic [NH_W-1:0]  nhits, rp, ann;
  logic             rd_vld;
  logic [BIN_W-1:0] rad_q;
  logic [CNT_W-1:0] peak_q;

  logic [CW-1:0]    cx [NPTS];
  logic [CW-1:0]    cy [NPTS];
  logic [CNT_W-1:0] pk [NPTS];
  logic [BIN_W-1:0] pkb [NPTS];
  logic [BIN_W-1:0] hbin [NPTS];

  logic hit_acc, eoe_acc, clr, rd_en, buf_full;
  logic [2*COORD_W-1:0] rd_data;
  logic [BIN_W-1:0]     rbin;
  logic                 in_band;

  assign in_ready = (state == ST_ACC);
  assign hit_acc  = in_valid && in_ready && !in_eoe;
  assign eoe_acc  = in_valid && in_ready && in_eoe;
  assign clr      = (state == ST_CLR);
  assign buf_full = (nhits == NH_W'(HIT_DEPTH));
  assign rd_en    = (state == ST_ANN) && (rp < nhits);

  for (genvar g = 0; g < NPTS; g++) begin : g_pt
    localparam int GXI = g % GRID_N;
    localparam int GYI = g / GRID_N;
    assign cx[g] = CW'(cfg_org_x) + CW'(GXI) * CW'(cfg_step);
    assign cy[g] = CW'(cfg_org_y) + CW'(GYI) * CW'(cfg_step);

    ringcand_dist #(.HW(COORD_W), .CW(CW), .NBINS(NBINS), .SHIFT(BIN_SHIFT)) u_dist (
      .hx(in_x), .hy(in_y), .cx(cx[g]), .cy(cy[g]), .bin(hbin[g]));

    ringcand_hist #(.NBINS(NBINS), .CNT_W(CNT_W)) u_hist (
      .clk(clk), .rst(rst), .clr(clr), .inc(hit_acc), .bin(hbin[g]),
      .peak(pk[g]), .peak_bin(pkb[g]));
  end

  ringcand_hitbuf #(.W(2*COORD_W), .DEPTH(HIT_DEPTH)) u_buf (
    .clk(clk), .we(hit_acc && !buf_full), .waddr(nhits[AW-1:0]),
    .wdata({in_x, in_y}), .re(rd_en), .raddr(rp[AW-1:0]), .rdata(rd_data));

  ringcand_dist #(.HW(COORD_W), .CW(CW), .NBINS(NBINS), .SHIFT(BIN_SHIFT)) u_rdist (
    .hx(rd_data[2*COORD_W-1:COORD_W]), .hy(rd_data[COORD_W-1:0]),
    .cx(cx[gp]), .cy(cy[gp]), .bin(rbin));

  assign in_band = ({1'b0, rbin} == {1'b0, rad_q}) ||
                   ({1'b0, rbin} == {1'b0, rad_q} + 1'b1) ||
                   ({1'b0, rbin} + 1'b1 == {1'b0, rad_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CLR; gp <= '0; any_cand <= 1'b0; nhits <= '0;
      rp <= '0; ann <= '0; rd_vld <= 1'b0; rad_q <= '0; peak_q <= '0;
      out_valid <= 1'b0; out_gx <= '0; out_gy <= '0; out_radius <= '0;
      out_peak <= '0; out_annulus <= '0; out_none <= 1'b0; overflow <= 1'b0;
    end else begin
      case (state)
        ST_CLR: begin
          nhits <= '0; any_cand <= 1'b0; gp <= '0;
          state <= ST_ACC;
        end
        ST_ACC: begin
          if (hit_acc) begin
            if (buf_full) overflow <= 1'b1;
            else          nhits <= nhits + 1'b1;
          end
          if (eoe_acc) begin
            gp    <= '0;
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (pk[gp] >= cfg_thresh) begin
            rad_q <= pkb[gp]; peak_q <= pk[gp];
            rp <= '0; rd_vld <= 1'b0; ann <= '0;
            state <= ST_ANN;
          end else if (gp == GP_W'(NPTS - 1)) begin
            if (any_cand) state <= ST_CLR;
            else begin
              out_valid <= 1'b1; out_none <= 1'b1; out_gx <= '0; out_gy <= '0;
              out_radius <= '0; out_peak <= '0; out_annulus <= '0;
              state <= ST_OUT;
            end
          end else begin
            gp <= gp + 1'b1;
          end
        end
        ST_ANN: begin
          if (rd_en) rp <= rp + 1'b1;
          rd_vld <= rd_en;
          if (rd_vld && in_band) ann <= ann + 1'b1;
          if (!rd_en && !rd_vld) begin
            out_valid <= 1'b1; out_none <= 1'b0;
            out_gx <= gp[GX_W-1:0]; out_gy <= gp[GP_W-1:GX_W];
            out_radius <= rad_q; out_peak <= peak_q; out_annulus <= ann;
            any_cand <= 1'b1;
            state <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            if (out_none || gp == GP_W'(NPTS - 1)) state <= ST_CLR;
            else begin
              gp    <= gp + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        default: state <= ST_CLR;
      endcase
    end
  end

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid &&
      $stable({out_gx, out_gy, out_radius, out_peak, out_annulus, out_none}));
  assert_thresh_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_none) |-> out_peak >= cfg_thresh);
  assert_none_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_none) |-> (out_peak == '0 && out_annulus == '0));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_acc && buf_full) |=> overflow);
  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  assert_ann_bound_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_annulus <= NH_W'(HIT_DEPTH));
endmodule

// File: tb/ringcand_finder_bench.sv
module ringcand_finder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_org_x = 8'd32, cfg_org_y = 8'd32, cfg_step = 8'd64, cfg_thresh = 8'd8;
  logic in_valid = 1'b0, in_eoe = 1'b0;
  logic [7:0] in_x = '0, in_y = '0;
  logic in_ready, out_valid, out_none, overflow;
  logic out_ready = 1'b0;
  logic [1:0] out_gx, out_gy;
  logic [3:0] out_radius;
  logic [7:0] out_peak;
  logic [6:0] out_annulus;

  always #2 clk = ~clk;

  ringcand_finder u_ringcand_finder (
    .clk(clk), .rst(rst), .cfg_org_x(cfg_org_x), .cfg_org_y(cfg_org_y),
    .cfg_step(cfg_step), .cfg_thresh(cfg_thresh), .in_valid(in_valid),
    .in_ready(in_ready), .in_eoe(in_eoe), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_gx(out_gx), .out_gy(out_gy),
    .out_radius(out_radius), .out_peak(out_peak), .out_annulus(out_annulus),
    .out_none(out_none), .overflow(overflow));

  int errors = 0, checks = 0, cycles = 0;
  int hx_q[$], hy_q[$];
  logic [23:0] exp_q[$];
  string cur_req = "R4";
  bit stall_en = 1'b0;

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // distance bin as required by R1/R2
  function automatic int mbin(int hx, int hy, int cx, int cy);
    int dx, dy, mx, mn, s;
    dx = (hx > cx) ? hx - cx : cx - hx;
    dy = (hy > cy) ? hy - cy : cy - hy;
    mx = (dx > dy) ? dx : dy;
    mn = (dx > dy) ? dy : dx;
    s = (mx + mn / 2) >> 3;
    return (s > 15) ? 15 : s;
  endfunction

  task automatic build_model();
    int any;
    any = 0;
    for (int gy = 0; gy < 4; gy++) begin
      for (int gx = 0; gx < 4; gx++) begin
        int h[16];
        int cx, cy, pk, rad, ann;
        cx = cfg_org_x + gx * cfg_step;
        cy = cfg_org_y + gy * cfg_step;
        for (int b = 0; b < 16; b++) h[b] = 0;
        foreach (hx_q[i]) begin
          int b;
          b = mbin(hx_q[i], hy_q[i], cx, cy);
          if (h[b] < 255) h[b]++;
        end
        pk = h[0]; rad = 0;
        for (int b = 1; b < 16; b++) if (h[b] > pk) begin pk = h[b]; rad = b; end
        if (pk >= cfg_thresh) begin
          ann = 0;
          for (int i = 0; i < hx_q.size() && i < 64; i++) begin
            int d;
            d = mbin(hx_q[i], hy_q[i], cx, cy) - rad;
            if (d >= -1 && d <= 1) ann++;
          end
          exp_q.push_back({1'b0, 2'(gx), 2'(gy), 4'(rad), 8'(pk), 7'(ann)});
          any = 1;
        end
      end
    end
    if (any == 0) exp_q.push_back(24'h800000);
  endtask

  task automatic put(input bit eoe, input int x, input int y);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_eoe = eoe; in_x = 8'(x); in_y = 8'(y);
    @(negedge clk);
    in_valid = 1'b0; in_eoe = 1'b0;
  endtask

  task automatic run_event(input int thr, input string req);
    cfg_thresh = 8'(thr);
    cur_req = req;
    build_model();
    foreach (hx_q[i]) put(1'b0, hx_q[i], hy_q[i]);
    put(1'b1, 0, 0);
    // the cycle after the end-of-event beat: input must be closed (R9)
    check("R9", in_ready == 1'b0, in_ready, 0);
    while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    check(req, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  // record monitor: a handshake seen at negedge completes at the next edge
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      logic [23:0] got;
      got = {out_none, out_gx, out_gy, out_radius, out_peak, out_annulus};
      if (exp_q.size() == 0) check(cur_req, 1'b0, got, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check(cur_req, got == e, got, e);
      end
    end
  end

  always @(posedge clk) out_ready <= stall_en ? ($urandom_range(0, 2) == 0) : 1'b1;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10", out_valid == 1'b0 && overflow == 1'b0, {out_valid, overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", out_valid == 1'b0 && overflow == 1'b0, {out_valid, overflow}, 0);

    // ring around center (1,1) plus noise: R1 R2 R4 R5 R6
    begin
      int ox[16] = '{40, 0, -40, 0, 28, -28, 28, -28, 37, -37, 37, -37, 15, -15, 15, -15};
      int oy[16] = '{0, 40, 0, -40, 28, 28, -28, -28, 15, 15, -15, -15, 37, 37, -37, -37};
      for (int i = 0; i < 16; i++) begin hx_q.push_back(96 + ox[i]); hy_q.push_back(96 + oy[i]); end
      hx_q.push_back(200); hy_q.push_back(20);
      hx_q.push_back(10);  hy_q.push_back(240);
    end
    run_event(8, "R6");

    // sparse event, no candidate: R8, also proves previous counts were cleared (R9)
    hx_q.delete(); hy_q.delete();
    hx_q.push_back(5); hy_q.push_back(5);
    hx_q.push_back(250); hy_q.push_back(130);
    hx_q.push_back(128); hy_q.push_back(60);
    run_event(8, "R8");
    check("R7", overflow == 1'b0, overflow, 0);

    // tied bins and low threshold, with output stalls: R4 R5
    stall_en = 1'b1;
    hx_q.delete(); hy_q.delete();
    hx_q.push_back(32);  hy_q.push_back(32);
    hx_q.push_back(96);  hy_q.push_back(32);
    hx_q.push_back(160); hy_q.push_back(200);
    run_event(1, "R5");

    // empty event, threshold zero: every center qualifies at radius 0 (R4)
    hx_q.delete(); hy_q.delete();
    run_event(0, "R4");

    // 300 hits on one spot: saturation (R3) and store overflow (R7)
    hx_q.delete(); hy_q.delete();
    for (int i = 0; i < 300; i++) begin hx_q.push_back(100); hy_q.push_back(100); end
    run_event(200, "R3");
    check("R7", overflow == 1'b1, overflow, 1);

    // mixed event after overflow; overflow stays sticky (R7) and results fresh (R9)
    stall_en = 1'b0;
    hx_q.delete(); hy_q.delete();
    for (int i = 0; i < 20; i++) begin hx_q.push_back(150 + (i % 5) * 3); hy_q.push_back(170 - i); end
    run_event(4, "R9");
    check("R7", overflow == 1'b1, overflow, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule